// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Multiplexer

This block builds the byte carried in timeslot 16 of every frame of a 16-frame E1 multiframe on the transmit side. The framer's timing logic asks for a byte by presenting a frame number (0 to 15) on a valid/ready request stream. The block answers on a valid/ready output stream with the timeslot-16 byte and a flag that tells the transmitter to replace the whole frame with all ones.

A host writes sixteen signalling entries. Entry 0 holds the spare and remote-alarm bits of the multiframe alignment word. Entries 1 to 15 each hold two ABCD nibbles: the high nibble belongs to telephone channel N and the low nibble to channel N+15. Host writes go to a pending bank. That bank is copied into the active bank when a frame-0 request is accepted, so every multiframe is built from one consistent set of values. Mode inputs select channel-associated signalling, common-channel pass-through, a timeslot-16 alarm or a whole-frame alarm. The mode inputs are sampled when a request is accepted.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in that same cycle. An output stays valid, with `out_data` and `out_all_ones` held steady, until `out_ready` is seen high. A result appears on the output one clock edge after its request is accepted.

Top module: `e1_ts16_cas_mux`

## Requirements
- R1: For frame 0 in signalling mode, `out_data[7:4]` is 0000 and `out_data[3:0]` equals bits [3:0] of entry 0, bit 2 being the remote multiframe-loss flag. Bit 7 is transmitted first.
- R2: For frame N (1 to 15) in signalling mode, `out_data` equals entry N: bits [7:4] are ABCD of channel N and bits [3:0] are ABCD of channel N+15.
- R3: When `mf_lost` is high at acceptance of a frame-0 request in signalling mode, `out_data[2]` is 1 whatever entry 0 holds.
- R4: A host write does not affect the output until a frame-0 request is accepted. From that frame on, through frames 1 to 15, the newly written values are used.
- R5: A host write to an index of 1 to 15 with data bits [7:4] equal to 0000 sets `nibble_err`, which stays set until reset. The value is still transmitted unchanged.
- R6: With `ccs_en` high and no alarm active, `out_data` equals `ccs_byte` for any frame and `out_all_ones` is 0.
- R7: With `ts16_ais` high and `all_ais` low, `out_data` is 8'hFF and `out_all_ones` is 0, even when `ccs_en` is high.
- R8: With `all_ais` high, `out_data` is 8'hFF and `out_all_ones` is 1.
- R9: While `out_valid` is high and `out_ready` is low, `req_ready` is low and the output holds its value. A request held during that stall is accepted in the cycle `out_ready` returns.
- R10: After reset, `out_valid` and `nibble_err` are 0 and `req_ready` is 1. Entry 0 is 8'h0B and entries 1 to 15 are 8'hDD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe into the pending bank |
| host_wr_idx | input | 4 | Entry index written |
| host_wr_data | input | 8 | Entry value written |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Frame request accepted when high with valid |
| req_frame | input | 4 | Frame number within the multiframe |
| mf_lost | input | 1 | Local multiframe alignment lost; forces the remote-alarm bit |
| ccs_en | input | 1 | Common-channel pass-through mode |
| ccs_byte | input | 8 | Byte passed through in common-channel mode |
| ts16_ais | input | 1 | Force timeslot 16 to all ones |
| all_ais | input | 1 | Force the whole frame to all ones |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Timeslot-16 byte |
| out_all_ones | output | 1 | Replace every timeslot of this frame with ones |
| nibble_err | output | 1 | Sticky flag for an all-zero channel-N nibble written |

## Verification
On every cycle, the assertions check four things: the output holds steady under a stall; the whole-frame alarm always comes with an all-ones byte; a frame-0 signalling byte never has a nonzero alignment nibble; and the active bank and the error flag change only as permitted. The bench scenarios cover the behaviours that depend on values chosen by the host. These are the exact byte mapping per frame, the delayed effect of writes until the next multiframe boundary, the forcing of the remote-loss bit, the order of precedence among the modes, and the way a held request is accepted when the stall ends.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  typedef enum logic [1:0] {
    K_CAS   = 2'd0,
    K_CCS   = 2'd1,
    K_TSAIS = 2'd2,
    K_ALLAIS = 2'd3
  } ts16_kind_e;

  // Power-up contents: spare bits set, remote-loss clear; unused B,C,D = 1,0,1.
  function automatic logic [7:0] entry_reset(input int idx);
    return (idx == 0) ? 8'h0B : 8'hDD;
  endfunction
endpackage

// File: rtl/e1cas_bank.sv
module e1cas_bank #(
  parameter int FRAMES = 16,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              commit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic              err
);
  localparam int NIB = BYTE_W / 2;

  logic [FRAMES-1:0][BYTE_W-1:0] pend_q;
  logic [FRAMES-1:0][BYTE_W-1:0] act_q;
  logic                          err_q;

  for (genvar g = 0; g < FRAMES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= e1cas_pkg::entry_reset(g);
        act_q[g]  <= e1cas_pkg::entry_reset(g);
      end else begin
        if (wr_en && (wr_idx == IDX_W'(g)))
          pend_q[g] <= wr_data;
        if (commit)
          act_q[g] <= pend_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (wr_en && (wr_idx != '0) && (wr_data[BYTE_W-1 -: NIB] == '0))
      err_q <= 1'b1;
  end

  // Frame 0 opens a new multiframe and reads the freshly committed values.
  assign rd_data = (rd_idx == '0) ? pend_q[0] : act_q[rd_idx];
  assign err     = err_q;

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R5
endmodule

// File: rtl/e1cas_compose.sv
module e1cas_compose #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]      frame,
  input  logic [BYTE_W-1:0]     entry,
  input  logic                  mf_lost,
  input  logic                  ccs_en,
  input  logic [BYTE_W-1:0]     ccs_byte,
  input  logic                  ts16_ais,
  input  logic                  all_ais,
  output logic [BYTE_W-1:0]     byte_o,
  output logic                  all_ones,
  output e1cas_pkg::ts16_kind_e kind
);
  import e1cas_pkg::*;
  localparam int NIB   = BYTE_W / 2;
  localparam int Y_POS = NIB - 2;

  logic [BYTE_W-1:0] cas_byte;

  always_comb begin
    cas_byte = entry;
    if (frame == '0) begin
      cas_byte[BYTE_W-1 -: NIB] = '0;
      cas_byte[Y_POS]           = entry[Y_POS] | mf_lost;
    end
  end

  always_comb begin
    all_ones = 1'b0;
    if (all_ais) begin
      kind     = K_ALLAIS;
      byte_o   = '1;
      all_ones = 1'b1;
    end else if (ts16_ais) begin
      kind   = K_TSAIS;
      byte_o = '1;
    end else if (ccs_en) begin
      kind   = K_CCS;
      byte_o = ccs_byte;
    end else begin
      kind   = K_CAS;
      byte_o = cas_byte;
    end
  end
endmodule

// File: rtl/e1_ts16_cas_mux.sv
module e1_ts16_cas_mux #(
  parameter int FRAMES = 16,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [IDX_W-1:0]  host_wr_idx,
  input  logic [BYTE_W-1:0] host_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_frame,
  input  logic              mf_lost,
  input  logic              ccs_en,
  input  logic [BYTE_W-1:0] ccs_byte,
  input  logic              ts16_ais,
  input  logic              all_ais,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_all_ones,
  output logic              nibble_err
);
  import e1cas_pkg::*;
  localparam int NIB = BYTE_W / 2;

  logic              accept;
  logic              commit;
  logic [BYTE_W-1:0] entry;
  logic [BYTE_W-1:0] next_byte;
  logic              next_ones;
  ts16_kind_e        next_kind;

  logic              vld_q;
  logic [BYTE_W-1:0] data_q;
  logic              ones_q;
  ts16_kind_e        kind_q;
  logic [IDX_W-1:0]  frame_q;

  assign req_ready = !vld_q || out_ready;
  assign accept    = req_valid && req_ready;
  assign commit    = accept && (req_frame == '0);

  e1cas_bank #(.FRAMES(FRAMES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_en),
    .wr_idx  (host_wr_idx),
    .wr_data (host_wr_data),
    .commit  (commit),
    .rd_idx  (req_frame),
    .rd_data (entry),
    .err     (nibble_err)
  );

  e1cas_compose #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_compose (
    .frame    (req_frame),
    .entry    (entry),
    .mf_lost  (mf_lost),
    .ccs_en   (ccs_en),
    .ccs_byte (ccs_byte),
    .ts16_ais (ts16_ais),
    .all_ais  (all_ais),
    .byte_o   (next_byte),
    .all_ones (next_ones),
    .kind     (next_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      ones_q  <= 1'b0;
      kind_q  <= K_CAS;
      frame_q <= '0;
    end else if (accept) begin
      vld_q   <= 1'b1;
      data_q  <= next_byte;
      ones_q  <= next_ones;
      kind_q  <= next_kind;
      frame_q <= req_frame;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid    = vld_q;
  assign out_data     = data_q;
  assign out_all_ones = ones_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_all_ones))); // R9
  AST_FRAME_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_all_ones) |-> (out_data == '1)); // R8
  AST_ALIGN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q == K_CAS && frame_q == '0) |-> (out_data[BYTE_W-1 -: NIB] == '0)); // R1
  AST_ALARM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q == K_TSAIS) |-> (out_data == '1 && !out_all_ones)); // R7
endmodule

// File: tb/e1_ts16_cas_mux_test.sv
module e1_ts16_cas_mux_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr_en = 1'b0;
  logic [3:0] host_wr_idx = '0;
  logic [7:0] host_wr_data = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_frame = '0;
  logic       mf_lost = 1'b0;
  logic       ccs_en = 1'b0;
  logic [7:0] ccs_byte = '0;
  logic       ts16_ais = 1'b0;
  logic       all_ais = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_all_ones;
  logic       nibble_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  e1_ts16_cas_mux uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_frame(req_frame),
    .mf_lost(mf_lost), .ccs_en(ccs_en), .ccs_byte(ccs_byte),
    .ts16_ais(ts16_ais), .all_ais(all_ais),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_all_ones(out_all_ones), .nibble_err(nibble_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] idx, input logic [7:0] val);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_idx = idx; host_wr_data = val;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  // Issue one request and leave the result visible at a falling edge.
  task automatic ask(input logic [3:0] fr);
    @(negedge clk);
    req_valid = 1'b1; req_frame = fr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 out_valid", {7'd0, out_valid}, 8'd0);
    check("R10 nibble_err", {7'd0, nibble_err}, 8'd0);
    check("R10 req_ready", {7'd0, req_ready}, 8'd1);
  endtask

  task automatic t_defaults;
    ask(4'd0);
    check("R10 R1 frame0 default", out_data, 8'h0B);
    check("R1 valid", {7'd0, out_valid}, 8'd1);
    ask(4'd5);
    check("R10 R2 frame5 default", out_data, 8'hDD);
  endtask

  task automatic t_commit;
    host_write(4'd0, 8'hF9);
    for (int i = 1; i < 16; i++) host_write(4'(i), 8'(8'h10 * i + 8'(16 - i)));
    ask(4'd3);
    check("R4 before boundary", out_data, 8'hDD);
    ask(4'd0);
    check("R1 R4 frame0 after commit", out_data, 8'h09);
    ask(4'd3);
    check("R2 R4 frame3", out_data, 8'h3D);
    ask(4'd15);
    check("R2 frame15", out_data, 8'hF1);
    host_write(4'd3, 8'h77);
    ask(4'd3);
    check("R4 write mid-multiframe held", out_data, 8'h3D);
  endtask

  task automatic t_mflost;
    mf_lost = 1'b1;
    ask(4'd0);
    check("R3 Y forced", out_data, 8'h0D);
    mf_lost = 1'b0;
    ask(4'd0);
    check("R3 Y released", out_data, 8'h09);
  endtask

  task automatic t_zero_nibble;
    check("R5 err clear before", {7'd0, nibble_err}, 8'd0);
    host_write(4'd0, 8'h05);
    check("R5 index0 no err", {7'd0, nibble_err}, 8'd0);
    host_write(4'd7, 8'h05);
    check("R5 err set", {7'd0, nibble_err}, 8'd1);
    host_write(4'd7, 8'h99);
    host_write(4'd0, 8'h09);
    ask(4'd0);
    host_write(4'd7, 8'h05);
    ask(4'd0);
    ask(4'd7);
    check("R5 still sent", out_data, 8'h05);
    check("R5 sticky", {7'd0, nibble_err}, 8'd1);
  endtask

  task automatic t_modes;
    ccs_en = 1'b1; ccs_byte = 8'h3C;
    ask(4'd4);
    check("R6 ccs byte", out_data, 8'h3C);
    check("R6 ccs no frame ones", {7'd0, out_all_ones}, 8'd0);
    ask(4'd0);
    check("R6 ccs frame0", out_data, 8'h3C);
    ts16_ais = 1'b1;
    ask(4'd4);
    check("R7 ts16 alarm over ccs", out_data, 8'hFF);
    check("R7 no frame ones", {7'd0, out_all_ones}, 8'd0);
    all_ais = 1'b1;
    ask(4'd2);
    check("R8 all alarm byte", out_data, 8'hFF);
    check("R8 frame ones", {7'd0, out_all_ones}, 8'd1);
    all_ais = 1'b0; ts16_ais = 1'b0; ccs_en = 1'b0;
    ask(4'd2);
    check("R8 R6 back to cas", out_data, 8'h2E);
    check("R8 ones cleared", {7'd0, out_all_ones}, 8'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    ask(4'd2);
    check("R9 stall valid", {7'd0, out_valid}, 8'd1);
    check("R9 stall ready low", {7'd0, req_ready}, 8'd0);
    req_valid = 1'b1; req_frame = 4'd15;
    @(negedge clk);
    @(negedge clk);
    check("R9 held data", out_data, 8'h2E);
    check("R9 ready still low", {7'd0, req_ready}, 8'd0);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 held request taken", out_data, 8'hF1);
    @(negedge clk);
    check("R9 drained", {7'd0, out_valid}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_commit();
    t_mflost();
    t_zero_nibble();
    t_modes();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule